// File: doc/BRIEF.md
# Multi-Stream Strided Prefetch Buffer

This block sits beside a cache and watches the block addresses of its misses. A miss that no stream is tracking opens a new stream. The stream then fetches the blocks that follow the missed block at a fixed step, until it has a set number of blocks either outstanding or buffered. The step is one block in sequential mode. In strided mode it is a configured distance. Lines that come back from memory are kept in a small FIFO owned by that stream, not in the cache.

A later miss on the block at the head of a stream's FIFO is served straight from the buffer. That entry is then popped, and the stream fetches one more block to refill the freed slot. Several streams run at once. Each one stays inside the page of the miss that opened it. When every stream is in use, the oldest allocation is recycled. Memory requests carry a stream number so that returning lines reach the right FIFO.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset no prefetch request is raised and no buffer hit is reported.
- R2: A miss to block X that matches no stream opens a stream that requests X+s, X+2s, … in that order, one per accepted request, until DEPTH (4) blocks are outstanding or buffered for it; s is 1 when `mode_strided` is 0.
- R3: When `mode_strided` is 1 the step s is `stride_cfg`, with a value of 0 treated as 1; the step is captured when the stream opens.
- R4: A stream never requests a block outside its page. The page is the block address bits above the low PG_W (6) bits, and it is taken from the miss that opened the stream.
- R5: A miss whose block equals the head of a stream's FIFO, with that line already returned, raises `hit_valid` in the same cycle, with `hit_data` and `hit_sid`. It pops the entry and lets the stream request one further block.
- R6: Streams are recycled in order of allocation, so the ninth new stream replaces stream 0. The replaced stream's buffered lines are discarded, and a later miss on its old head is not a hit.
- R7: Responses still pending for a replaced stream are discarded when they arrive. The new stream issues no request until all of them have arrived, so its FIFO holds only its own lines.
- R8: At most one request is raised per cycle, and `req_sid` names the stream it belongs to. Streams with a free slot are granted round-robin, starting after the last granted stream. Responses for one stream return in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_strided | input | 1 | 0: step of one block, 1: step of `stride_cfg` |
| stride_cfg | input | PG_W | Step in blocks for strided mode |
| miss_valid | input | 1 | Cache miss present this cycle |
| miss_blk | input | BA_W | Block address of the miss |
| hit_valid | output | 1 | Miss served from a stream FIFO |
| hit_sid | output | SID_W | Stream that served the hit |
| hit_data | output | DATA_W | Line returned on a hit |
| req_valid | output | 1 | Prefetch request |
| req_ready | input | 1 | Memory accepts the request |
| req_blk | output | BA_W | Block address to fetch |
| req_sid | output | SID_W | Stream that owns the request |
| rsp_valid | input | 1 | Line returned from memory |
| rsp_sid | input | SID_W | Stream the line belongs to |
| rsp_data | input | DATA_W | Returned line |

## Verification
The hardest state to reach from the ports is a stream being recycled while memory still owes it lines, since that stale data could land in the new stream's FIFO. The bench holds back its memory responses, fills all eight streams with outstanding requests, and then opens a ninth stream on a fresh page. It then releases the responses and checks two things: the new stream's first hit carries its own line, and the old head no longer hits. Round-robin order is exposed in a similar way, by holding `req_ready` low while two streams open and then reading the grant sequence.

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int BA_W   = 26,
  parameter int DATA_W = 32,
  parameter int NS     = 8,
  parameter int DEPTH  = 4,
  parameter int PG_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_strided,
  input  logic [PG_W-1:0]   stride_cfg,
  input  logic              miss_valid,
  input  logic [BA_W-1:0]   miss_blk,
  output logic              hit_valid,
  output logic [$clog2(NS)-1:0] hit_sid,
  output logic [DATA_W-1:0] hit_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BA_W-1:0]   req_blk,
  output logic [$clog2(NS)-1:0] req_sid,
  input  logic              rsp_valid,
  input  logic [$clog2(NS)-1:0] rsp_sid,
  input  logic [DATA_W-1:0] rsp_data
);
  localparam int SID_W = $clog2(NS);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = $clog2(DEPTH);
  localparam int TW    = BA_W - PG_W;

  logic              vld  [NS];
  logic [TW-1:0]     pg   [NS];
  logic [PG_W:0]     nof  [NS];
  logic [PG_W-1:0]   hof  [NS];
  logic [PG_W-1:0]   str  [NS];
  logic [CW-1:0]     cnt  [NS];
  logic [CW-1:0]     fill [NS];
  logic [CW-1:0]     drop [NS];
  logic [PW-1:0]     rp   [NS];
  logic [PW-1:0]     wp   [NS];
  logic [DATA_W-1:0] mem  [NS][DEPTH];

  logic [SID_W-1:0] aptr, rr, sel, idx;
  logic             any_match, alloc;
  logic [NS-1:0]    el, iss_v, pop_v, rs_v, wr_v;
  logic [PG_W-1:0]  seff;

  wire [TW-1:0]   mpg  = miss_blk[BA_W-1:PG_W];
  wire [PG_W-1:0] moff = miss_blk[PG_W-1:0];

  assign seff = (mode_strided && stride_cfg != '0) ? stride_cfg : PG_W'(1);

  always_comb begin
    hit_valid = 1'b0;
    hit_sid   = '0;
    any_match = 1'b0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (miss_valid && vld[s] && cnt[s] != '0 && pg[s] == mpg && hof[s] == moff) begin
        any_match = 1'b1;
        if (fill[s] != '0) begin
          hit_valid = 1'b1;
          hit_sid   = SID_W'(s);
        end
      end
    end
    alloc = miss_valid && !any_match;
  end

  assign hit_data = mem[hit_sid][rp[hit_sid]];

  always_comb begin
    for (int s = 0; s < NS; s++)
      el[s] = vld[s] && cnt[s] < CW'(DEPTH) && !nof[s][PG_W] && drop[s] == '0 &&
              !(alloc && aptr == SID_W'(s));
    req_valid = 1'b0;
    sel = '0;
    idx = '0;
    for (int k = 0; k < NS; k++) begin
      idx = rr + SID_W'(k);
      if (!req_valid && el[idx]) begin
        req_valid = 1'b1;
        sel = idx;
      end
    end
    for (int s = 0; s < NS; s++) begin
      iss_v[s] = req_valid && req_ready && sel == SID_W'(s);
      pop_v[s] = hit_valid && hit_sid == SID_W'(s);
      rs_v[s]  = rsp_valid && rsp_sid == SID_W'(s);
      wr_v[s]  = rs_v[s] && drop[s] == '0;
    end
  end

  assign req_sid = sel;
  assign req_blk = {pg[sel], nof[sel][PG_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aptr <= '0;
      rr   <= '0;
      for (int s = 0; s < NS; s++) begin
        vld[s] <= 1'b0;  pg[s] <= '0;   nof[s] <= '0;  hof[s] <= '0;
        str[s] <= '0;    cnt[s] <= '0;  fill[s] <= '0; drop[s] <= '0;
        rp[s]  <= '0;    wp[s] <= '0;
      end
    end else begin
      if (req_valid && req_ready) rr <= sel + 1'b1;
      if (alloc) aptr <= aptr + 1'b1;
      for (int s = 0; s < NS; s++) begin
        if (alloc && aptr == SID_W'(s)) begin
          vld[s]  <= 1'b1;
          pg[s]   <= mpg;
          str[s]  <= seff;
          nof[s]  <= {1'b0, moff} + {1'b0, seff};
          hof[s]  <= moff + seff;
          cnt[s]  <= '0;
          fill[s] <= '0;
          rp[s]   <= '0;
          wp[s]   <= '0;
          drop[s] <= drop[s] + cnt[s] - fill[s] - CW'(rs_v[s]);
        end else begin
          if (iss_v[s]) nof[s] <= nof[s] + {1'b0, str[s]};
          cnt[s]  <= cnt[s] + CW'(iss_v[s]) - CW'(pop_v[s]);
          fill[s] <= fill[s] + CW'(wr_v[s]) - CW'(pop_v[s]);
          if (wr_v[s]) begin
            mem[s][wp[s]] <= rsp_data;
            wp[s] <= wp[s] + 1'b1;
          end
          if (pop_v[s]) begin
            rp[s]  <= rp[s] + 1'b1;
            hof[s] <= hof[s] + str[s];
          end
          if (rs_v[s] && !wr_v[s]) drop[s] <= drop[s] - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_chk
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= CW'(DEPTH));
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt[g] <= $past(cnt[g]) + 1'b1);
    a_r7_fill_le_cnt: assert property (@(posedge clk) disable iff (!rst_n)
      fill[g] <= cnt[g]);
    a_r8_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_sid == SID_W'(g) && drop[g] == '0) |-> fill[g] < cnt[g]);
  end
endmodule

// File: tb/stream_prefetcher_tb.sv
module stream_prefetcher_tb;
  localparam int CLK = 10;
  localparam int BA_W = 26, DATA_W = 32, PG_W = 6;

  logic clk = 0, rst_n = 0;
  logic mode_strided = 0;
  logic [PG_W-1:0] stride_cfg = '0;
  logic miss_valid = 0;
  logic [BA_W-1:0] miss_blk = '0;
  logic hit_valid, req_valid;
  logic [2:0] hit_sid, req_sid;
  logic [DATA_W-1:0] hit_data;
  logic req_ready = 1;
  logic [BA_W-1:0] req_blk;
  logic rsp_valid = 0;
  logic [2:0] rsp_sid = '0;
  logic [DATA_W-1:0] rsp_data = '0;

  int checks = 0, errors = 0;
  logic [BA_W-1:0] lblk [0:511];
  logic [2:0]      lsid [0:511];
  int ln = 0, qrd = 0;
  logic rsp_en = 1;

  stream_prefetcher u_dut (.*);

  always #(CLK/2) clk = ~clk;

  function automatic logic [BA_W-1:0] mk(int page, int off);
    return {page[BA_W-PG_W-1:0], off[PG_W-1:0]};
  endfunction
  function automatic logic [DATA_W-1:0] dat(logic [BA_W-1:0] b);
    return {6'b0, b} ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) if (rst_n && req_valid && req_ready) begin
    lblk[ln] <= req_blk; lsid[ln] <= req_sid; ln <= ln + 1;
  end

  always @(negedge clk) begin
    if (rsp_en && qrd < ln) begin
      rsp_valid = 1; rsp_sid = lsid[qrd]; rsp_data = dat(lblk[qrd]); qrd = qrd + 1;
    end else rsp_valid = 0;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_dut();
    @(negedge clk); rst_n = 0; mode_strided = 0; stride_cfg = '0; req_ready = 1;
    wait_cyc(2); rst_n = 1;
  endtask

  task automatic do_miss(logic [BA_W-1:0] b, output logic h, output logic [DATA_W-1:0] d,
                         output logic [2:0] s);
    @(negedge clk); miss_valid = 1; miss_blk = b;
    #1; h = hit_valid; d = hit_data; s = hit_sid;
    @(negedge clk); miss_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0; wait_cyc(2);
    chk(!req_valid, "R1 req", 32'(req_valid), 0);
    chk(!hit_valid, "R1 hit", 32'(hit_valid), 0);
    rst_n = 1; wait_cyc(1);
    chk(!req_valid, "R1 req idle", 32'(req_valid), 0);
  endtask

  task automatic t_seq();
    logic h; logic [DATA_W-1:0] d; logic [2:0] s; int b;
    reset_dut(); b = ln;
    do_miss(mk(18, 5), h, d, s);
    chk(!h, "R2 first miss", 32'(h), 0);
    wait_cyc(20);
    chk(ln - b == 4, "R2 count", ln - b, 4);
    for (int i = 0; i < 4; i++) begin
      chk(lblk[b+i] == mk(18, 6 + i), "R2 seq addr", 32'(lblk[b+i]), 32'(mk(18, 6 + i)));
      chk(lsid[b+i] == 0, "R8 sid", 32'(lsid[b+i]), 0);
    end
    do_miss(mk(18, 6), h, d, s);
    chk(h, "R5 hit", 32'(h), 1);
    chk(d == dat(mk(18, 6)), "R5 data", d, dat(mk(18, 6)));
    chk(s == 0, "R5 sid", 32'(s), 0);
    wait_cyc(5);
    chk(ln - b == 5, "R5 refill count", ln - b, 5);
    chk(lblk[b+4] == mk(18, 10), "R5 refill addr", 32'(lblk[b+4]), 32'(mk(18, 10)));
  endtask

  task automatic t_stride();
    logic h; logic [DATA_W-1:0] d; logic [2:0] s; int b;
    reset_dut(); mode_strided = 1; stride_cfg = 3; b = ln;
    do_miss(mk(40, 2), h, d, s);
    wait_cyc(20);
    chk(ln - b == 4, "R3 count", ln - b, 4);
    for (int i = 0; i < 4; i++)
      chk(lblk[b+i] == mk(40, 5 + 3*i), "R3 stride addr", 32'(lblk[b+i]), 32'(mk(40, 5 + 3*i)));
    do_miss(mk(40, 5), h, d, s);
    chk(h && d == dat(mk(40, 5)), "R3 hit data", d, dat(mk(40, 5)));
    wait_cyc(5);
    chk(lblk[b+4] == mk(40, 17), "R3 refill addr", 32'(lblk[b+4]), 32'(mk(40, 17)));
  endtask

  task automatic t_page();
    logic h; logic [DATA_W-1:0] d; logic [2:0] s; int b;
    reset_dut(); b = ln;
    do_miss(mk(7, 61), h, d, s);
    wait_cyc(20);
    chk(ln - b == 2, "R4 count at edge", ln - b, 2);
    chk(lblk[b+1] == mk(7, 63), "R4 last addr", 32'(lblk[b+1]), 32'(mk(7, 63)));
    do_miss(mk(7, 62), h, d, s);
    chk(h, "R4 hit", 32'(h), 1);
    wait_cyc(8);
    chk(ln - b == 2, "R4 no cross", ln - b, 2);
  endtask

  task automatic t_replace();
    logic h; logic [DATA_W-1:0] d; logic [2:0] s; int b;
    reset_dut();
    for (int p = 0; p < 8; p++) do_miss(mk(100 + p, 0), h, d, s);
    wait_cyc(40); b = ln;
    do_miss(mk(200, 0), h, d, s);
    wait_cyc(15);
    chk(ln - b == 4, "R6 new stream count", ln - b, 4);
    chk(lsid[b] == 0 && lblk[b] == mk(200, 1), "R6 victim is stream 0",
        32'({lsid[b], lblk[b]}), 32'({3'd0, mk(200, 1)}));
    do_miss(mk(101, 1), h, d, s);
    chk(h && s == 1, "R6 stream 1 kept", 32'(s), 1);
    do_miss(mk(100, 1), h, d, s);
    chk(!h, "R6 old head dropped", 32'(h), 0);
    wait_cyc(15);
  endtask

  task automatic t_stale();
    logic h; logic [DATA_W-1:0] d; logic [2:0] s; int b;
    reset_dut(); rsp_en = 0; b = ln;
    for (int p = 0; p < 8; p++) do_miss(mk(300 + p, 0), h, d, s);
    wait_cyc(40);
    chk(ln - b == 32, "R7 all issued", ln - b, 32);
    do_miss(mk(400, 8), h, d, s);
    wait_cyc(5);
    chk(ln - b == 32, "R7 wait for stale", ln - b, 32);
    rsp_en = 1;
    wait_cyc(80);
    chk(ln - b == 36, "R7 new issued", ln - b, 36);
    do_miss(mk(400, 9), h, d, s);
    chk(h && d == dat(mk(400, 9)), "R7 own data", d, dat(mk(400, 9)));
    do_miss(mk(300, 1), h, d, s);
    chk(!h, "R7 old stream gone", 32'(h), 0);
    wait_cyc(20);
  endtask

  task automatic t_rr();
    logic h; logic [DATA_W-1:0] d; logic [2:0] s; int b;
    reset_dut(); req_ready = 0; b = ln;
    do_miss(mk(500, 0), h, d, s);
    do_miss(mk(501, 0), h, d, s);
    @(negedge clk); req_ready = 1;
    wait_cyc(15);
    chk(ln - b == 8, "R8 count", ln - b, 8);
    for (int i = 0; i < 8; i++)
      chk(lsid[b+i] == 3'(i % 2), "R8 round robin", 32'(lsid[b+i]), i % 2);
    wait_cyc(10);
  endtask

  initial begin
    #(CLK * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_stride();
    t_page();
    t_replace();
    t_stale();
    t_rr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule